// File: doc/BRIEF.md
# Gated Period-Match Timer/Counter

A 16-bit up-counter that runs until it reaches the value held in a period register, returns to zero on the following count and carries on. Its count pulses come from one of four sources chosen in a control register: the system clock, the system clock enabled only while an external gate is high, rising edges of an external clock brought into the system clock domain, or an external clock divided in its own domain with only the divided result crossing over. A prescaler of 1, 8, 64 or 256 sits in front of the counter for every source.

A sticky event flag rises when the counter wraps at the period value. In gated mode it rises instead when the gate falls. Software clears it by writing. Through a small register port, software sets the mode, the prescale and the period, and can load the count directly. An idle input, together with a control bit, stops counting while the rest of the system is in a low-power idle state.

Top module: `gated_match_timer`

## Requirements
- R1: After a synchronous reset the control register is 0, the count is 0, the period is 0xFFFF and the flag is 0. A read returns, one cycle after `rd_addr` is presented, the register at that address: 0 control, 1 count, 2 period, 3 flag in bit 0 with the other bits zero.
- R2: On each count pulse the count rises by one. A pulse that finds the count equal to the period loads 0 instead. With period 0 the count therefore stays at 0 and wraps on every pulse.
- R3: Outside gated mode, the flag is set in the cycle in which a count pulse wraps the counter from the period value to zero.
- R4: Control bits [5:4] choose the prescale: 00 gives one count per source pulse, 01 one per 8, 10 one per 64 and 11 one per 256.
- R5: Control bit 15 enables the timer. Bit 1 selects an external source. With bit 1 at 0, bit 6 at 1 selects gated mode and bit 6 at 0 selects the system clock, whatever bit 2 holds. With bit 1 at 1, bit 2 at 1 selects synchronized external counting and bit 2 at 0 selects asynchronous external counting.
- R6: In synchronized external mode, each rising edge of `ext_clk` becomes one source pulse once it has passed a two-flop synchronizer.
- R7: In asynchronous external mode, rising edges of `ext_clk` drive a divider in the `ext_clk` domain. Each completed division toggles a signal, and after synchronization each toggle gives one count pulse. Only reset clears this divider.
- R8: In gated mode the system clock is counted only while the synchronized `gate_in` is high. The flag is set on a synchronized falling edge of the gate while enabled, and not on a period wrap.
- R9: With control bit 13 set, asserting `idle_in` halts the count and the prescaler. Counting resumes when `idle_in` drops. With bit 13 clear, `idle_in` has no effect.
- R10: With control bit 15 clear, the count and the prescaler hold their values.
- R11: The flag stays set until a write to address 3 with data bit 0 equal to 0. If a set event and that clear fall in the same cycle, the flag ends up set.
- R12: A write to address 1 loads the count on the next edge, takes precedence over a count pulse in the same cycle, suppresses any wrap flag for that cycle and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| ext_clk | input | 1 | External count clock |
| gate_in | input | 1 | External gate level |
| idle_in | input | 1 | System idle indication |
| event_flag | output | 1 | Sticky period/gate event flag |

## Verification
Two collisions matter most. A hardware flag set can land in the same cycle as a software clear, and a count load can land in the same cycle as a count pulse. The bench holds a flag-clear write steady across several wrap cycles, and holds a count write steady across several pulses at a 1:1 prescale, so that both collisions occur many times. A behavioural model applies the stated priorities (set beats clear, load beats pulse and suppresses the wrap flag) and compares the read data and the flag on every clock.

// File: rtl/gmt_pkg.sv
package gmt_pkg;
  localparam int PS_W = 8;

  localparam int CTL_EN   = 15;
  localparam int CTL_IDLE = 13;
  localparam int CTL_GATE = 6;
  localparam int CTL_PSH  = 5;
  localparam int CTL_PSL  = 4;
  localparam int CTL_SYNC = 2;
  localparam int CTL_SRC  = 1;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_PER = 2'd2;
  localparam logic [1:0] A_FLG = 2'd3;

  typedef enum logic [1:0] {
    MODE_INT   = 2'd0,
    MODE_GATED = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_ASYNC = 2'd3
  } mode_e;

  function automatic logic [PS_W-1:0] ps_last(input logic [1:0] sel);
    logic [PS_W-1:0] v;
    case (sel)
      2'b00:   v = PS_W'(0);
      2'b01:   v = PS_W'(7);
      2'b10:   v = PS_W'(63);
      default: v = PS_W'(255);
    endcase
    return v;
  endfunction

  function automatic mode_e decode_mode(input logic src, input logic gate, input logic sync);
    if (src) return sync ? MODE_SYNC : MODE_ASYNC;
    return gate ? MODE_GATED : MODE_INT;
  endfunction
endpackage

// File: rtl/gmt_sync.sv
module gmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], d};
  end

  assign q      = sh[STAGES-1];
  assign q_prev = sh[STAGES];
endmodule

// File: rtl/gmt_prescaler.sv
module gmt_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  input  logic [PS_W-1:0] last,
  output logic            tick
);
  logic [PS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (adv)     cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  assign tick = adv && (cnt == last);
endmodule

// File: rtl/gmt_ext_divider.sv
module gmt_ext_divider #(
  parameter int PS_W = 8
) (
  input  logic            ext_clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [PS_W-1:0] last,
  output logic            toggle
);
  logic [PS_W-1:0] cnt;

  always_ff @(posedge ext_clk) begin
    if (rst) begin
      cnt    <= '0;
      toggle <= 1'b0;
    end else if (adv) begin
      if (cnt == last) begin
        cnt    <= '0;
        toggle <= ~toggle;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gated_match_timer.sv
module gated_match_timer #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_clk,
  input  logic              gate_in,
  input  logic              idle_in,
  output logic              event_flag
);
  import gmt_pkg::*;

  localparam int N_SYNC = 3;
  localparam int SY_GATE = 0;
  localparam int SY_EXT  = 1;
  localparam int SY_TOG  = 2;

  logic [DATA_W-1:0] ctl_q, cnt_q, per_q;
  logic              flag_q;
  logic              en, run, wr_cnt, at_period, tick, ps_tick, wrap, set_evt, src_pulse;
  logic              async_tog;
  logic [PS_W-1:0]   ps_sel_last;
  mode_e             mode;
  logic [N_SYNC-1:0] sy_in, sy_q, sy_qd;
  logic              gate_lvl, gate_lvl_d;

  assign en          = ctl_q[CTL_EN];
  assign run         = en && !(ctl_q[CTL_IDLE] && idle_in);
  assign mode        = decode_mode(ctl_q[CTL_SRC], ctl_q[CTL_GATE], ctl_q[CTL_SYNC]);
  assign ps_sel_last = ps_last(ctl_q[CTL_PSH:CTL_PSL]);
  assign wr_cnt      = wr_en && (wr_addr == A_CNT);
  assign at_period   = (cnt_q == per_q);

  // Input synchronizers: gate level, external clock level, async divider toggle
  assign sy_in[SY_GATE] = gate_in;
  assign sy_in[SY_EXT]  = ext_clk;
  assign sy_in[SY_TOG]  = async_tog;

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    gmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d      (sy_in[i]),
      .q      (sy_q[i]),
      .q_prev (sy_qd[i])
    );
  end

  assign gate_lvl   = sy_q[SY_GATE];
  assign gate_lvl_d = sy_qd[SY_GATE];

  // Divider in the external clock domain for asynchronous counting
  gmt_ext_divider #(.PS_W(PS_W)) u_ext_div (
    .ext_clk (ext_clk),
    .rst     (rst),
    .adv     (run && (mode == MODE_ASYNC)),
    .last    (ps_sel_last),
    .toggle  (async_tog)
  );

  always_comb begin
    case (mode)
      MODE_INT:   src_pulse = 1'b1;
      MODE_GATED: src_pulse = gate_lvl;
      MODE_SYNC:  src_pulse = sy_q[SY_EXT] && !sy_qd[SY_EXT];
      default:    src_pulse = 1'b0;
    endcase
  end

  gmt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk  (clk),
    .rst  (rst),
    .clr  (wr_cnt),
    .adv  (run && src_pulse),
    .last (ps_sel_last),
    .tick (ps_tick)
  );

  assign tick    = (mode == MODE_ASYNC) ? (run && (sy_q[SY_TOG] ^ sy_qd[SY_TOG])) : ps_tick;
  assign wrap    = tick && at_period && !wr_cnt;
  assign set_evt = (mode == MODE_GATED) ? (en && gate_lvl_d && !gate_lvl) : wrap;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (tick)   cnt_q <= at_period ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      per_q <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_CTL) ctl_q <= wr_data;
      if (wr_addr == A_PER) per_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                               flag_q <= 1'b0;
    else if (set_evt)                                      flag_q <= 1'b1;
    else if (wr_en && (wr_addr == A_FLG) && !wr_data[0])   flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTL:   rd_data <= ctl_q;
        A_CNT:   rd_data <= cnt_q;
        A_PER:   rd_data <= per_q;
        default: rd_data <= {{(DATA_W-1){1'b0}}, flag_q};
      endcase
    end
  end

  assign event_flag = flag_q;
endmodule

// File: rtl/gmt_checker.sv
module gmt_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              idle_in,
  input logic [DATA_W-1:0] ctl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] per_q,
  input logic              flag_q,
  input logic              tick,
  input logic              wr_cnt,
  input logic              at_period,
  input gmt_pkg::mode_e    mode,
  input logic              gate_lvl,
  input logic              gate_lvl_d
);
  import gmt_pkg::*;

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_q == '0 && per_q == '1 && ctl_q == '0 && !flag_q));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && at_period && !wr_cnt) |=> (cnt_q == '0));

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !at_period && !wr_cnt) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

  p_gate_noflag_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_GATED && !(gate_lvl_d && !gate_lvl) && !flag_q) |=> !flag_q);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[CTL_IDLE] && idle_in && !wr_cnt) |=> $stable(cnt_q));

  p_disabled_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_EN] && !wr_cnt) |=> $stable(cnt_q));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && wr_addr == A_FLG && !wr_data[0])) |=> flag_q);

  p_count_load_r12: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wr_data)));
endmodule

bind gated_match_timer gmt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .idle_in    (idle_in),
  .ctl_q      (ctl_q),
  .cnt_q      (cnt_q),
  .per_q      (per_q),
  .flag_q     (flag_q),
  .tick       (tick),
  .wr_cnt     (wr_cnt),
  .at_period  (at_period),
  .mode       (mode),
  .gate_lvl   (gate_lvl),
  .gate_lvl_d (gate_lvl_d)
);

// File: tb/gated_match_timer_test.sv
module gated_match_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [15:0] C_EN   = 16'h8000;
  localparam logic [15:0] C_IDL  = 16'h2000;
  localparam logic [15:0] C_GATE = 16'h0040;
  localparam logic [15:0] C_SYNC = 16'h0004;
  localparam logic [15:0] C_SRC  = 16'h0002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        ext_clk = 1'b0;
  logic        gate_in = 1'b0;
  logic        idle_in = 1'b0;
  logic        event_flag;

  gated_match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk), .gate_in(gate_in),
    .idle_in(idle_in), .event_flag(event_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    ext_half = 1;
  int    ext_ph   = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Reference model state
  logic [15:0] m_ctl, m_cnt, m_per, m_rd;
  bit          m_flag;
  int          m_pcnt, m_adiv;
  bit          m_atog;
  bit [2:0]    m_g, m_e, m_t;

  function automatic logic [15:0] ps(input int sel);
    return 16'(sel << 4);
  endfunction

  function automatic int last_of(input logic [1:0] sel);
    case (sel)
      2'b00: return 0;
      2'b01: return 7;
      2'b10: return 63;
      default: return 255;
    endcase
  endfunction

  always @(posedge ext_clk) begin
    if (rst) begin
      m_adiv = 0;
      m_atog = 0;
    end else if (m_ctl[15] && m_ctl[1] && !m_ctl[2] && !(m_ctl[13] && idle_in)) begin
      if (m_adiv == last_of(m_ctl[5:4])) begin
        m_adiv = 0;
        m_atog = !m_atog;
      end else begin
        m_adiv = m_adiv + 1;
      end
    end
  end

  always @(posedge clk) begin : mdl
    bit en, run, gated, sy, asy, srcp, tick, wcnt, fall, wrapev, setev;
    int last;
    if (rst) begin
      m_ctl = 0; m_cnt = 0; m_per = 16'hFFFF; m_flag = 0; m_rd = 0;
      m_pcnt = 0; m_g = 0; m_e = 0; m_t = 0;
    end else begin
      en    = m_ctl[15];
      run   = en && !(m_ctl[13] && idle_in);
      gated = !m_ctl[1] && m_ctl[6];
      sy    = m_ctl[1] && m_ctl[2];
      asy   = m_ctl[1] && !m_ctl[2];
      last  = last_of(m_ctl[5:4]);
      wcnt  = wr_en && (wr_addr == 2'd1);
      fall  = m_g[2] && !m_g[1];
      case (rd_addr)
        2'd0: m_rd = m_ctl;
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = m_per;
        default: m_rd = {15'd0, m_flag};
      endcase
      tick = 0;
      if (asy) begin
        tick = run && (m_t[1] != m_t[2]);
      end else begin
        srcp = gated ? m_g[1] : (sy ? (m_e[1] && !m_e[2]) : 1'b1);
        if (run && srcp) begin
          if (m_pcnt == last) begin tick = 1; m_pcnt = 0; end
          else m_pcnt = (m_pcnt + 1) % 256;
        end
      end
      if (wcnt) m_pcnt = 0;
      wrapev = tick && (m_cnt == m_per) && !wcnt;
      if (wcnt) m_cnt = wr_data;
      else if (tick) m_cnt = (m_cnt == m_per) ? 16'd0 : m_cnt + 16'd1;
      setev = gated ? (en && fall) : wrapev;
      if (setev) m_flag = 1;
      else if (wr_en && wr_addr == 2'd3 && !wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 2'd0) m_ctl = wr_data;
      if (wr_en && wr_addr == 2'd2) m_per = wr_data;
      m_g = {m_g[1:0], gate_in};
      m_e = {m_e[1:0], ext_clk};
      m_t = {m_t[1:0], m_atog};
    end
  end

  task automatic check16(input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", cur_req, what, cyc, got, exp);
    end
  endtask

  // Compare on every falling edge, rotate the read address, pace the external clock
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (!rst) begin
        check16("rd_data", rd_data, m_rd);
        check16("event_flag", {15'd0, event_flag}, {15'd0, m_flag});
      end
      rd_addr = rd_addr + 2'd1;
      if (cyc > WATCHDOG) begin
        fails++;
        $display("FAIL %s watchdog: cycles %0d expected below %0d", cur_req, cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
      if (ext_half > 0) begin
        ext_ph++;
        if (ext_ph >= ext_half) begin
          ext_ph = 0;
          #1 ext_clk = ~ext_clk;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic hold_wr(input logic [1:0] a, input logic [15:0] d, input int n);
    wr_en = 1; wr_addr = a; wr_data = d;
    repeat (n) @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gate_pulse(input int hi, input int lo);
    gate_in = 1; wait_cyc(hi);
    gate_in = 0; wait_cyc(lo);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    cur_req = "R1"; wait_cyc(8);

    cur_req = "R2"; wr(2'd2, 16'd5); wr(2'd0, C_EN); wait_cyc(30);
    wr(2'd2, 16'd0); wait_cyc(10);
    wr(2'd2, 16'd5); wait_cyc(12);

    cur_req = "R3"; wr(2'd3, 16'd0); wait_cyc(20);

    cur_req = "R11"; hold_wr(2'd3, 16'd0, 14); wait_cyc(4);
    hold_wr(2'd3, 16'd1, 4); wr(2'd3, 16'd0); wait_cyc(3);

    cur_req = "R4"; wr(2'd0, C_EN | ps(1)); wait_cyc(80);
    wr(2'd2, 16'd3); wr(2'd0, C_EN | ps(2)); wait_cyc(300);
    wr(2'd2, 16'd2); wr(2'd0, C_EN | ps(3)); wait_cyc(800);

    cur_req = "R12"; wr(2'd2, 16'd9); wr(2'd0, C_EN | ps(1)); wait_cyc(5);
    wr(2'd1, 16'd2); wait_cyc(20);
    wr(2'd0, C_EN); hold_wr(2'd1, 16'd9, 5); wait_cyc(10);
    wr(2'd1, 16'h0100); wait_cyc(6);

    cur_req = "R10"; wr(2'd1, 16'd0); wr(2'd0, ps(1)); wait_cyc(20);
    wr(2'd0, C_EN | ps(1)); wait_cyc(20);

    cur_req = "R9"; wr(2'd0, C_EN | C_IDL); idle_in = 1; wait_cyc(12);
    idle_in = 0; wait_cyc(10);
    wr(2'd0, C_EN); idle_in = 1; wait_cyc(12); idle_in = 0; wait_cyc(4);

    cur_req = "R6"; wr(2'd2, 16'd4); ext_half = 3; wr(2'd0, C_EN | C_SRC | C_SYNC); wait_cyc(100);
    wr(2'd0, C_EN | C_SRC | C_SYNC | ps(1)); wait_cyc(200);

    cur_req = "R7"; ext_half = 2; wr(2'd0, C_EN | C_SRC); wait_cyc(100);
    wr(2'd0, C_EN | C_SRC | ps(1)); wait_cyc(200);
    cur_req = "R9"; wr(2'd0, C_EN | C_SRC | C_IDL); idle_in = 1; wait_cyc(20); idle_in = 0; wait_cyc(20);

    cur_req = "R8"; ext_half = 0; wr(2'd3, 16'd0); wr(2'd2, 16'd3); wr(2'd0, C_EN | C_GATE);
    gate_pulse(10, 5); gate_pulse(3, 6); wr(2'd3, 16'd0); gate_pulse(20, 4);
    cur_req = "R5"; wr(2'd3, 16'd0); wr(2'd0, C_EN | C_GATE | C_SYNC);
    gate_pulse(7, 5); wr(2'd0, C_EN | C_GATE | C_SRC | C_SYNC); ext_half = 2; wait_cyc(40);
    wr(2'd0, C_EN | C_SYNC); wait_cyc(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule